// File: doc/BRIEF.md
# Configurable Width Stack Engine

This block runs the hardware stack of an 8-bit microcontroller. It keeps a stack pointer split into a low byte and a high byte. It turns one-cycle commands into the RAM writes and reads needed for a single-byte push or pop, a subroutine call, interrupt entry, a return and an interrupt return. The block drives a synchronous single-port RAM. Write data and the write enable act on the clock edge. Read data comes back one cycle after the address.

A mode input chooses 8-bit or 16-bit stack addressing. The mode is sampled when a command is accepted.

- **16-bit mode:** the whole pointer steps, and the stack can sit anywhere in the 64 KiB address space.
- **8-bit mode:** only the low byte moves, and the RAM sees a high address byte of zero, so the stack stays in bank 0. The high pointer byte is then free for software to use as a general data register.

Both pointer bytes can be read and written through a small register port. A write that arrives while a sequence is running is held back and applied when the sequence finishes. Stack overflow and underflow are not detected.

Top module: `stk_engine`

## Requirements
- R1: After reset both pointer bytes read 00h, and `busy`, `done` and `ram_we` are low.
- R2: Push (`cmd_op` = 0) moves the pointer down by one, then writes `push_data[7:0]` at the new address. `busy` is high for one cycle and `done` follows.
- R3: Pop (`cmd_op` = 1) reads the byte at the current address, then moves the pointer up by one. The byte appears on `pop_data` in the `done` cycle.
- R4: Call (`cmd_op` = 2) pushes `pc_in[7:0]` and then `pc_in[15:8]`, so the high byte ends at the lower address. Interrupt entry (`cmd_op` = 4) does the same and then pushes `flags_in` last. The pointer ends 2 or 3 lower.
- R5: Return (`cmd_op` = 3) pops the program counter high byte, then the low byte. Interrupt return (`cmd_op` = 5) pops flags, then the high byte, then the low byte. `pc_out` and `flags_out` are valid in the `done` cycle.
- R6: With `wide_mode` = 0 at acceptance, the RAM address high byte is 00h and only the low pointer byte moves, wrapping modulo 256. The high pointer byte keeps its value.
- R7: With `wide_mode` = 1 the whole 16-bit pointer steps and wraps modulo 65536, so a push from 0000h writes at FFFFh.
- R8: While `busy` is high, new commands are ignored. Codes 6 and 7 are ignored at any time and cause no RAM write and no pointer change.
- R9: The register port selects the low byte with `reg_sel` = 0 and the high byte with `reg_sel` = 1. `reg_rdata` shows the selected byte combinationally. A write while idle shows on the next cycle.
- R10: A register write while `busy` is high, or in the same cycle as an accepted command, does not touch the pointer until the sequence ends. The command uses the old pointer. In the `done` cycle the written byte replaces that byte of the stepped pointer.
- R11: `done` is a single-cycle pulse, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects 16-bit stack addressing, 0 selects 8-bit |
| cmd_req | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 call, 3 return, 4 interrupt entry, 5 interrupt return) |
| push_data | input | 8 | Byte for a push |
| pc_in | input | 16 | Program counter to save |
| flags_in | input | 8 | Flags byte to save on interrupt entry |
| busy | output | 1 | A command sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pop_data | output | 8 | Byte returned by a pop |
| pc_out | output | 16 | Program counter restored by a return |
| flags_out | output | 8 | Flags restored by an interrupt return |
| reg_wr | input | 1 | Pointer byte write strobe |
| reg_sel | input | 1 | 0 low pointer byte, 1 high pointer byte |
| reg_wdata | input | 8 | Pointer byte write data |
| reg_rdata | output | 8 | Selected pointer byte |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, one cycle after address |

## Verification
Two situations bring a pointer register write together with stack work in the same cycle.

- **Write against command acceptance:** the bench drives a high-byte write in the very cycle a push is strobed. It then checks that the RAM write landed at the old pointer minus one and that the final pointer combines the written high byte with the stepped low byte.
- **Write against the final pointer step:** a low-byte write is issued in the first busy cycle of an interrupt entry. The bench reads the pointer mid-sequence to confirm it still steps normally, then checks that the written byte overrides the stepped low byte when `done` rises.

// File: rtl/stk_pkg.sv
package stk_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BW    = 8;
    localparam int AW    = 2 * BW;
    localparam int OPW   = 3;
    localparam int MAXB  = 3;
    localparam int IDXW  = $clog2(MAXB);

    typedef logic [BW-1:0]   byte_t;
    typedef logic [AW-1:0]   addr_t;
    typedef logic [IDXW-1:0] idx_t;

    typedef enum logic [OPW-1:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_INTR = 3'd4,
        OP_IRET = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {SL_DATA, SL_PCL, SL_PCH, SL_FLG} slot_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_TAIL} st_e;

    typedef struct packed {
        op_e   op;
        logic  wide;
        byte_t data;
        addr_t pc;
        byte_t flg;
    } cmd_t;

    // Control passed from the sequencer to the pointer unit each cycle
    typedef struct packed {
        logic dec;
        logic inc;
        logic fin;
        logic hold;
        logic wide;
    } step_t;

    function automatic logic op_valid(op_e op);
        case (op)
            OP_PUSH, OP_POP, OP_CALL, OP_RET, OP_INTR, OP_IRET: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_read(op_e op);
        case (op)
            OP_POP, OP_RET, OP_IRET: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic idx_t op_last(op_e op);
        case (op)
            OP_CALL, OP_RET:  return idx_t'(1);
            OP_INTR, OP_IRET: return idx_t'(2);
            default:          return idx_t'(0);
        endcase
    endfunction

    // Byte order: saves go PC low, PC high, flags; restores run in reverse
    function automatic slot_e op_slot(op_e op, idx_t idx);
        case (op)
            OP_CALL: return (idx == idx_t'(0)) ? SL_PCL : SL_PCH;
            OP_RET:  return (idx == idx_t'(0)) ? SL_PCH : SL_PCL;
            OP_INTR: begin
                if (idx == idx_t'(0)) return SL_PCL;
                if (idx == idx_t'(1)) return SL_PCH;
                return SL_FLG;
            end
            OP_IRET: begin
                if (idx == idx_t'(0)) return SL_FLG;
                if (idx == idx_t'(1)) return SL_PCH;
                return SL_PCL;
            end
            default: return SL_DATA;
        endcase
    endfunction

    function automatic byte_t slot_byte(cmd_t c, slot_e s);
        case (s)
            SL_PCL:  return c.pc[BW-1:0];
            SL_PCH:  return c.pc[AW-1:BW];
            SL_FLG:  return c.flg;
            default: return c.data;
        endcase
    endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_t step,
    input  logic  reg_wr,
    input  logic  reg_sel,
    input  byte_t reg_wdata,
    output byte_t spl_q,
    output byte_t sph_q,
    output addr_t addr_cur,
    output addr_t addr_dec
);
    timeunit 1ns;
    timeprecision 1ps;

    byte_t spl_dn, spl_up, sph_dn, sph_up;
    byte_t spl_n, sph_n;
    logic  pl_v, ph_v, pl_v_n, ph_v_n;
    byte_t pl_d, ph_d, pl_d_n, ph_d_n;
    logic  wr_lo, wr_hi;

    assign wr_lo = reg_wr & ~reg_sel;
    assign wr_hi = reg_wr &  reg_sel;

    // Carry into the high byte only in wide mode
    always_comb begin
        spl_dn = spl_q - byte_t'(1);
        spl_up = spl_q + byte_t'(1);
        sph_dn = sph_q;
        sph_up = sph_q;
        if (step.wide) begin
            if (spl_q == '0) sph_dn = sph_q - byte_t'(1);
            if (spl_q == '1) sph_up = sph_q + byte_t'(1);
        end
    end

    assign addr_cur = step.wide ? {sph_q, spl_q}   : {{BW{1'b0}}, spl_q};
    assign addr_dec = step.wide ? {sph_dn, spl_dn} : {{BW{1'b0}}, spl_dn};

    always_comb begin
        spl_n  = spl_q;
        sph_n  = sph_q;
        pl_v_n = pl_v;
        ph_v_n = ph_v;
        pl_d_n = pl_d;
        ph_d_n = ph_d;
        if (step.dec) begin
            spl_n = spl_dn;
            sph_n = sph_dn;
        end else if (step.inc) begin
            spl_n = spl_up;
            sph_n = sph_up;
        end
        if (step.fin) begin
            if (pl_v)  spl_n = pl_d;
            if (ph_v)  sph_n = ph_d;
            if (wr_lo) spl_n = reg_wdata;
            if (wr_hi) sph_n = reg_wdata;
            pl_v_n = 1'b0;
            ph_v_n = 1'b0;
        end else if (step.hold) begin
            if (wr_lo) begin
                pl_v_n = 1'b1;
                pl_d_n = reg_wdata;
            end
            if (wr_hi) begin
                ph_v_n = 1'b1;
                ph_d_n = reg_wdata;
            end
        end else begin
            if (wr_lo) spl_n = reg_wdata;
            if (wr_hi) sph_n = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spl_q <= '0;
            sph_q <= '0;
            pl_v  <= 1'b0;
            ph_v  <= 1'b0;
            pl_d  <= '0;
            ph_d  <= '0;
        end else begin
            spl_q <= spl_n;
            sph_q <= sph_n;
            pl_v  <= pl_v_n;
            ph_v  <= ph_v_n;
            pl_d  <= pl_d_n;
            ph_d  <= ph_d_n;
        end
    end

    a_r2_push_dec: assert property (@(posedge clk) disable iff (rst)
        (step.dec && !step.fin) |=> (spl_q == byte_t'($past(spl_q) - byte_t'(1))));

    a_r3_pop_inc: assert property (@(posedge clk) disable iff (rst)
        (step.inc && !step.fin) |=> (spl_q == byte_t'($past(spl_q) + byte_t'(1))));

    a_r6_high_kept: assert property (@(posedge clk) disable iff (rst)
        (!step.wide && (step.dec || step.inc) && !step.fin) |=> $stable(sph_q));

    a_r10_defer_hold: assert property (@(posedge clk) disable iff (rst)
        (step.hold && !step.fin && !step.dec && !step.inc) |=> ($stable(spl_q) && $stable(sph_q)));

    a_r8_one_dir: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step.dec, step.inc}));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_req,
    input  op_e   cmd_op,
    input  logic  cmd_wide,
    input  byte_t cmd_data,
    input  addr_t cmd_pc,
    input  byte_t cmd_flg,
    input  addr_t addr_cur,
    input  addr_t addr_dec,
    input  byte_t ram_rdata,
    output step_t step,
    output addr_t ram_addr,
    output byte_t ram_wdata,
    output logic  ram_we,
    output logic  busy,
    output logic  done,
    output byte_t pop_data,
    output addr_t pc_out,
    output byte_t flags_out
);
    timeunit 1ns;
    timeprecision 1ps;

    st_e   st;
    idx_t  idx;
    cmd_t  cmd_q;
    logic  cap_v;
    slot_e cap_slot;
    logic  done_q;
    logic  accept;
    logic  last;
    slot_e cur_slot;

    assign accept   = (st == ST_IDLE) && cmd_req && op_valid(cmd_op);
    assign last     = (idx == op_last(cmd_q.op));
    assign cur_slot = op_slot(cmd_q.op, idx);

    always_comb begin
        step.dec  = (st == ST_WR);
        step.inc  = (st == ST_RD);
        step.fin  = ((st == ST_WR) && last) || (st == ST_TAIL);
        step.hold = (st != ST_IDLE) || accept;
        step.wide = cmd_q.wide;
    end

    assign ram_addr  = (st == ST_WR) ? addr_dec : addr_cur;
    assign ram_we    = (st == ST_WR);
    assign ram_wdata = slot_byte(cmd_q, cur_slot);
    assign busy      = (st != ST_IDLE);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            idx       <= '0;
            cmd_q     <= '0;
            cap_v     <= 1'b0;
            cap_slot  <= SL_DATA;
            done_q    <= 1'b0;
            pop_data  <= '0;
            pc_out    <= '0;
            flags_out <= '0;
        end else begin
            done_q <= 1'b0;
            cap_v  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_q.op   <= cmd_op;
                        cmd_q.wide <= cmd_wide;
                        cmd_q.data <= cmd_data;
                        cmd_q.pc   <= cmd_pc;
                        cmd_q.flg  <= cmd_flg;
                        idx        <= '0;
                        st         <= op_is_read(cmd_op) ? ST_RD : ST_WR;
                    end
                end
                ST_WR: begin
                    if (last) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_RD: begin
                    cap_v    <= 1'b1;
                    cap_slot <= cur_slot;
                    if (last) st <= ST_TAIL;
                    else      idx <= idx + 1'b1;
                end
                default: begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end
            endcase
            // Read data from the previous cycle's address lands here
            if (cap_v) begin
                case (cap_slot)
                    SL_PCL:  pc_out[BW-1:0]  <= ram_rdata;
                    SL_PCH:  pc_out[AW-1:BW] <= ram_rdata;
                    SL_FLG:  flags_out       <= ram_rdata;
                    default: pop_data        <= ram_rdata;
                endcase
            end
        end
    end

    a_r6_bank0: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_q.wide) |-> (ram_addr[AW-1:BW] == '0));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_we_busy: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);

    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));
endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wide_mode,
    input  logic        cmd_req,
    input  logic [2:0]  cmd_op,
    input  logic [7:0]  push_data,
    input  logic [15:0] pc_in,
    input  logic [7:0]  flags_in,
    output logic        busy,
    output logic        done,
    output logic [7:0]  pop_data,
    output logic [15:0] pc_out,
    output logic [7:0]  flags_out,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [15:0] ram_addr,
    output logic [7:0]  ram_wdata,
    output logic        ram_we,
    input  logic [7:0]  ram_rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    step_t step;
    byte_t spl, sph;
    addr_t addr_cur, addr_dec;

    stk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_req   (cmd_req),
        .cmd_op    (op_e'(cmd_op)),
        .cmd_wide  (wide_mode),
        .cmd_data  (push_data),
        .cmd_pc    (pc_in),
        .cmd_flg   (flags_in),
        .addr_cur  (addr_cur),
        .addr_dec  (addr_dec),
        .ram_rdata (ram_rdata),
        .step      (step),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .busy      (busy),
        .done      (done),
        .pop_data  (pop_data),
        .pc_out    (pc_out),
        .flags_out (flags_out)
    );

    stk_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .spl_q     (spl),
        .sph_q     (sph),
        .addr_cur  (addr_cur),
        .addr_dec  (addr_dec)
    );

    assign reg_rdata = reg_sel ? sph : spl;
endmodule

// File: tb/test_stk_engine.sv
module test_stk_engine;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic        wide_mode, cmd_req, reg_wr, reg_sel, ram_we, busy, done;
    logic [2:0]  cmd_op;
    logic [7:0]  push_data, flags_in, pop_data, flags_out, reg_wdata, reg_rdata, ram_wdata, ram_rdata;
    logic [15:0] pc_in, pc_out, ram_addr;

    always #2 clk = ~clk;

    stk_engine i_stk_engine (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .push_data(push_data), .pc_in(pc_in), .flags_in(flags_in), .busy(busy), .done(done),
        .pop_data(pop_data), .pc_out(pc_out), .flags_out(flags_out), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    // Bench RAM, indexed by the low 10 address bits
    logic [7:0]  mem [1024];
    logic [15:0] last_waddr = 16'h0;
    int          wr_count = 0;
    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr[9:0]] <= ram_wdata;
            last_waddr <= ram_addr;
            wr_count   <= wr_count + 1;
        end
        ram_rdata <= mem[ram_addr[9:0]];
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {wide, op, arg, flags, exp_sp, exp_result, exp_flags}
    localparam logic [67:0] VEC [10] = '{
        {1'b1, 3'd0, 16'h00A5, 8'h00, 16'h01FF, 16'h0000, 8'h00},
        {1'b1, 3'd2, 16'h1234, 8'h00, 16'h01FD, 16'h0000, 8'h00},
        {1'b1, 3'd4, 16'hBEEF, 8'h5A, 16'h01FA, 16'h0000, 8'h00},
        {1'b1, 3'd5, 16'h0000, 8'h00, 16'h01FD, 16'hBEEF, 8'h5A},
        {1'b1, 3'd3, 16'h0000, 8'h00, 16'h01FF, 16'h1234, 8'h00},
        {1'b1, 3'd1, 16'h0000, 8'h00, 16'h0200, 16'h00A5, 8'h00},
        {1'b0, 3'd0, 16'h003C, 8'h00, 16'h02FF, 16'h0000, 8'h00},
        {1'b0, 3'd2, 16'h9876, 8'h00, 16'h02FD, 16'h0000, 8'h00},
        {1'b0, 3'd3, 16'h0000, 8'h00, 16'h02FF, 16'h9876, 8'h00},
        {1'b0, 3'd1, 16'h0000, 8'h00, 16'h0200, 16'h003C, 8'h00}
    };

    task automatic read_sp(output logic [15:0] v);
        reg_sel = 1'b0;
        #0.5;
        v[7:0] = reg_rdata;
        reg_sel = 1'b1;
        #0.5;
        v[15:8] = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op, input logic w, input logic [15:0] a, input logic [7:0] f);
        @(negedge clk);
        cmd_req = 1'b1; cmd_op = op; wide_mode = w;
        push_data = a[7:0]; pc_in = a; flags_in = f;
        @(negedge clk);
        cmd_req = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int k = 0; k < 20; k++) begin
            if (done === 1'b1) break;
            @(negedge clk);
        end
        chk(req, {31'b0, done}, 32'd1);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] sp;
        logic [67:0] v;
        int          wc;
        string       tag;
        rst = 1'b1; cmd_req = 1'b0; cmd_op = 3'd0; wide_mode = 1'b1;
        push_data = 8'h0; pc_in = 16'h0; flags_in = 8'h0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_sp(sp);
        chk("R1 pointer", {16'b0, sp}, 32'h0);
        chk("R1 busy/done/we", {29'b0, busy, done, ram_we}, 32'h0);

        // R9 register write while idle
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h02);
        read_sp(sp);
        chk("R9 write idle", {16'b0, sp}, 32'h0200);

        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            case (v[66:64])
                3'd0:       tag = "R2";
                3'd1:       tag = "R3";
                3'd2, 3'd4: tag = "R4";
                default:    tag = "R5";
            endcase
            if (!v[67]) tag = {tag, "/R6"};
            issue(v[66:64], v[67], v[63:48], v[47:40]);
            wait_done({tag, " done"});
            read_sp(sp);
            chk({tag, " pointer"}, {16'b0, sp}, {16'b0, v[39:24]});
            if (v[66:64] == 3'd1) chk({tag, " pop data"}, {24'b0, pop_data}, {24'b0, v[15:8]});
            if (v[66:64] == 3'd3 || v[66:64] == 3'd5) chk({tag, " pc"}, {16'b0, pc_out}, {16'b0, v[23:8]});
            if (v[66:64] == 3'd5) chk({tag, " flags"}, {24'b0, flags_out}, {24'b0, v[7:0]});
        end

        // R6 narrow writes went to bank 0
        chk("R6 bank0 address", {16'b0, last_waddr}, 32'h00FD);
        chk("R6 narrow pc low", {24'b0, mem[10'h0FE]}, 32'h76);
        // R4 byte order in memory
        chk("R4 pc low slot", {24'b0, mem[10'h1FE]}, 32'h34);
        chk("R4 pc high slot", {24'b0, mem[10'h1FD]}, 32'h12);
        chk("R4 intr pc high", {24'b0, mem[10'h1FB]}, 32'hBE);
        chk("R4 intr flags last", {24'b0, mem[10'h1FA]}, 32'h5A);

        // R11 done lasts one cycle
        @(negedge clk);
        chk("R11 single pulse", {30'b0, done, busy}, 32'h0);

        // R7 wide wrap
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
        issue(3'd0, 1'b1, 16'h0077, 8'h00);
        wait_done("R7 done");
        read_sp(sp);
        chk("R7 wrap down", {16'b0, sp}, 32'hFFFF);
        chk("R7 write addr", {16'b0, last_waddr}, 32'hFFFF);
        issue(3'd1, 1'b1, 16'h0000, 8'h00);
        wait_done("R7 done");
        read_sp(sp);
        chk("R7 wrap up", {16'b0, sp}, 32'h0000);
        chk("R7 pop data", {24'b0, pop_data}, 32'h77);

        // R8 command during busy is dropped
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h03);
        wc = wr_count;
        issue(3'd2, 1'b1, 16'hCAFE, 8'h00);
        chk("R8 busy", {31'b0, busy}, 32'd1);
        cmd_req = 1'b1; cmd_op = 3'd0; push_data = 8'h99;
        @(negedge clk);
        cmd_req = 1'b0;
        wait_done("R8 done");
        read_sp(sp);
        chk("R8 pointer", {16'b0, sp}, 32'h02FE);
        repeat (3) @(negedge clk);
        chk("R8 writes", wr_count - wc, 2);
        chk("R8 idle", {31'b0, busy}, 32'd0);

        // R8 reserved code ignored
        wc = wr_count;
        issue(3'd6, 1'b1, 16'h0055, 8'h00);
        chk("R8 reserved no busy", {31'b0, busy}, 32'd0);
        repeat (2) @(negedge clk);
        read_sp(sp);
        chk("R8 reserved pointer", {16'b0, sp}, 32'h02FE);
        chk("R8 reserved writes", wr_count - wc, 0);

        // R10 write during a sequence is deferred
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h03);
        issue(3'd4, 1'b1, 16'h1111, 8'h22);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40;
        @(negedge clk);
        reg_wr = 1'b0;
        read_sp(sp);
        chk("R10 not early", {24'b0, sp[7:0]}, 32'hFF);
        wait_done("R10 done");
        read_sp(sp);
        chk("R10 applied at end", {16'b0, sp}, 32'h0240);

        // R10 write in the accept cycle
        @(negedge clk);
        cmd_req = 1'b1; cmd_op = 3'd0; wide_mode = 1'b1; push_data = 8'h11;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h05;
        @(negedge clk);
        cmd_req = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
        wait_done("R10 done");
        read_sp(sp);
        chk("R10 old pointer used", {16'b0, last_waddr}, 32'h023F);
        chk("R10 merged pointer", {16'b0, sp}, 32'h053F);
        chk("R2 data written", {24'b0, mem[10'h23F]}, 32'h11);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule